// File: doc/BRIEF.md
# Two-Tier Overcurrent Hiccup Controller

This block guards the discharge path of a battery pack. Two comparators outside the block watch the drop across the current shunt. One trips at a moderate overload of about 150 mV of shunt drop, and the other at a hard short of about 375 mV. Each comparator reaches the block as a digital flag. Each flag has its own blanking count. A flag that stays high for its full count trips the block, and the discharge enable is then withdrawn.

After a trip of either tier, the enable stays low for an off interval of seventeen times the first-tier blanking count. The enable then returns by itself, with both blanking counts restarted. A fault that persists gives repeated trips, a hiccup pattern with a fixed duty cycle. A fault that clears lets normal operation continue without any outside action. Two status bits record which tier caused the most recent trip.

The two blanking counts set the timing. The first tier gets a long count so that surge currents into capacitive loads ride through. The second tier gets a short count for a fast reaction to a real short.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, `dsg_en` is 1 and both `last_trip_t1` and `last_trip_t2` are 0.
- R2: With the enable on, a first-tier flag sampled high on B1 consecutive rising edges trips the block on the B1-th edge, so `dsg_en` reads 0 right after that edge. B1 is the value of `tier1_blank`.
- R3: If the first-tier flag is sampled low before its count completes, the count starts again from zero. Two bursts of B1-1 high samples separated by one low sample therefore cause no trip.
- R4: A second-tier flag sampled high on B2 consecutive edges trips the block, even while first-tier blanking is in progress. If both tiers complete on the same edge, the trip is recorded as second tier.
- R5: After a trip of either tier, `dsg_en` stays 0 for exactly OFF_MULT×B1 sampled cycles (17×B1 by default). B1 is the first-tier count as it stood at the trip edge, and a later change to `tier1_blank` does not alter the interval in progress.
- R6: Both flags are ignored while the enable is off. When the enable returns, both counts restart from zero, so a fault that is still present trips again exactly B cycles after the return.
- R7: Once both flags are low, the enable stays on after the off interval ends.
- R8: At every trip, exactly one status bit is set: `last_trip_t1` for a first-tier trip and `last_trip_t2` for a second-tier trip. The bits hold until the next trip and are cleared only by reset. While `dsg_en` is 0, one of them is set.
- R9: A blanking count of 0 behaves as a count of 1, for both the trip time and the off interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tier1_flag | input | 1 | Lower-threshold overcurrent flag, already synchronised |
| tier2_flag | input | 1 | Higher-threshold overcurrent flag, already synchronised |
| tier1_blank | input | CNT_W | First-tier blanking count in cycles; also the base of the off interval |
| tier2_blank | input | CNT_W | Second-tier blanking count in cycles |
| dsg_en | output | 1 | Discharge enable, 1 = discharge path on |
| last_trip_t1 | output | 1 | Most recent trip came from the first tier |
| last_trip_t2 | output | 1 | Most recent trip came from the second tier |

## Verification
The bench builds the block with CNT_W = 4 and the default OFF_MULT of 17. With that width, the largest blanking count of 15 sits at the top of the counter's range, and its 255-cycle off interval is short enough to watch end to end. The same settings let the bench run whole hiccup cycles, with a fault held through a trip, a restart and a second trip, then a clean recovery. Zero counts on each tier and a same-edge collision of both tiers are also within reach.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } ocp_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_T1   = 2'b01,
        CAUSE_T2   = 2'b10
    } trip_cause_e;

    localparam int NUM_TIERS = 2;

    // Higher tier wins when both expire on the same edge.
    function automatic trip_cause_e pick_cause(input logic [NUM_TIERS-1:0] expired);
        return expired[1] ? CAUSE_T2 : CAUSE_T1;
    endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             flag,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;

    // A zero count is promoted to one sample.
    assign lim_eff = (limit == '0) ? ONE : limit;

    // cnt_q holds the number of earlier consecutive high samples.
    assign expired = flag && !clear && ((cnt_q + ONE) >= lim_eff) ;

    always_ff @(posedge clk) begin
        if (rst || clear || !flag) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/ocp_off_timer.sv
module ocp_off_timer #(
    parameter int CNT_W = 8,
    parameter int MULT  = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] base,
    output logic             done
);
    localparam int MW = $clog2(MULT + 1);
    localparam int OW = CNT_W + MW;

    logic [OW-1:0]    cnt_q;
    logic [OW-1:0]    len_q;
    logic [CNT_W-1:0] base_eff;

    assign base_eff = (base == '0) ? CNT_W'(1) : base;
    assign done     = run && ((cnt_q + OW'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            len_q <= OW'(base_eff) * OW'(MULT);
        end else if (run && !done) begin
            cnt_q <= cnt_q + OW'(1);
        end
    end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int OFF_MULT = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tier1_flag,
    input  logic             tier2_flag,
    input  logic [CNT_W-1:0] tier1_blank,
    input  logic [CNT_W-1:0] tier2_blank,
    output logic             dsg_en,
    output logic             last_trip_t1,
    output logic             last_trip_t2
);
    localparam int NT = NUM_TIERS;

    ocp_state_e  state_q;
    trip_cause_e cause_q;
    logic        in_off;
    logic        trip;
    logic        off_done;

    logic [NT-1:0]    flag_v;
    logic [NT-1:0]    exp_v;
    logic [CNT_W-1:0] lim_v [NT];

    assign in_off   = (state_q == ST_OFF);
    assign flag_v   = {tier2_flag, tier1_flag};
    assign lim_v[0] = tier1_blank;
    assign lim_v[1] = tier2_blank;
    assign trip     = |exp_v;

    for (genvar t = 0; t < NT; t++) begin : g_tier
        ocp_blank_timer #(.CNT_W(CNT_W)) u_blank (
            .clk     (clk),
            .rst     (rst),
            .clear   (in_off),
            .flag    (flag_v[t]),
            .limit   (lim_v[t]),
            .expired (exp_v[t])
        );
    end

    ocp_off_timer #(.CNT_W(CNT_W), .MULT(OFF_MULT)) u_off (
        .clk  (clk),
        .rst  (rst),
        .load (!in_off && trip),
        .run  (in_off),
        .base (tier1_blank),
        .done (off_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_RUN: if (trip) begin
                    state_q <= ST_OFF;
                    cause_q <= pick_cause(exp_v);
                end
                ST_OFF: if (off_done) begin
                    state_q <= ST_RUN;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign dsg_en       = (state_q == ST_RUN);
    assign last_trip_t1 = (cause_q == CAUSE_T1);
    assign last_trip_t2 = (cause_q == CAUSE_T2);

endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
    parameter int CNT_W    = 8,
    parameter int OFF_MULT = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             tier1_flag,
    input logic             tier2_flag,
    input logic [CNT_W-1:0] tier1_blank,
    input logic [CNT_W-1:0] tier2_blank,
    input logic             dsg_en,
    input logic             last_trip_t1,
    input logic             last_trip_t2
);
    localparam int RW = CNT_W + 1;
    localparam int LW = CNT_W + $clog2(OFF_MULT + 1);

    logic [RW-1:0] run1_q, run2_q;
    logic [LW-1:0] low_q, len_q;
    logic [RW-1:0] eff1, eff2;
    logic          ge1, ge2;

    assign eff1 = (tier1_blank == '0) ? RW'(1) : {1'b0, tier1_blank};
    assign eff2 = (tier2_blank == '0) ? RW'(1) : {1'b0, tier2_blank};
    assign ge1  = dsg_en && tier1_flag && (run1_q >= (eff1 - RW'(1)));
    assign ge2  = dsg_en && tier2_flag && (run2_q >= (eff2 - RW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            run1_q <= '0;
            run2_q <= '0;
            low_q  <= '0;
            len_q  <= '0;
        end else begin
            run1_q <= (dsg_en && tier1_flag) ? run1_q + RW'(run1_q != '1) : '0;
            run2_q <= (dsg_en && tier2_flag) ? run2_q + RW'(run2_q != '1) : '0;
            low_q  <= dsg_en ? '0 : low_q + LW'(1);
            if (dsg_en) len_q <= LW'(eff1) * LW'(OFF_MULT);
        end
    end

    AST_T1_FORCES_TRIP: assert property (@(posedge clk) disable iff (rst)
        ge1 |=> !dsg_en); // R2
    AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (rst)
        $fell(dsg_en) |-> ($past(ge1) || $past(ge2))); // R3
    AST_T2_FORCES_TRIP: assert property (@(posedge clk) disable iff (rst)
        ge2 |=> !dsg_en); // R4
    AST_T2_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        ($fell(dsg_en) && $past(ge2)) |-> last_trip_t2); // R4
    AST_OFF_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        !dsg_en |-> (low_q < len_q)); // R5
    AST_OFF_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(dsg_en) |-> ($past(low_q) == (len_q - LW'(1)))); // R5
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({last_trip_t1, last_trip_t2})); // R8
    AST_STATUS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !dsg_en |-> (last_trip_t1 || last_trip_t2)); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (last_trip_t1 || last_trip_t2) |=> (last_trip_t1 || last_trip_t2)); // R8

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(.CNT_W(CNT_W), .OFF_MULT(OFF_MULT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tier1_flag   (tier1_flag),
    .tier2_flag   (tier2_flag),
    .tier1_blank  (tier1_blank),
    .tier2_blank  (tier2_blank),
    .dsg_en       (dsg_en),
    .last_trip_t1 (last_trip_t1),
    .last_trip_t2 (last_trip_t2)
);

// File: tb/tb_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_ctrl;
    localparam int CNT_W = 4;
    localparam int MULT  = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tier1_flag = 1'b0;
    logic tier2_flag = 1'b0;
    logic [CNT_W-1:0] tier1_blank = '0;
    logic [CNT_W-1:0] tier2_blank = '0;
    logic dsg_en, last_trip_t1, last_trip_t2;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ocp_hiccup_ctrl #(.CNT_W(CNT_W), .OFF_MULT(MULT)) dut (
        .clk(clk), .rst(rst),
        .tier1_flag(tier1_flag), .tier2_flag(tier2_flag),
        .tier1_blank(tier1_blank), .tier2_blank(tier2_blank),
        .dsg_en(dsg_en), .last_trip_t1(last_trip_t1), .last_trip_t2(last_trip_t2)
    );

    // b1, b2, tier1 start/length, tier2 start/length, expected trip sample (0 = none), cause (1 = tier1, 2 = tier2)
    typedef struct packed {
        logic [7:0] b1, b2, s1, d1, s2, d2, fall;
        logic [1:0] cause;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  8'd2, 8'd0, 8'd10, 8'd0, 8'd0, 8'd3,  2'd1},  // R2 plain tier1
        '{8'd3,  8'd2, 8'd0, 8'd2,  8'd0, 8'd0, 8'd0,  2'd0},  // R2 short burst, no trip
        '{8'd5,  8'd2, 8'd0, 8'd20, 8'd2, 8'd3, 8'd4,  2'd2},  // R4 tier2 during tier1 blanking
        '{8'd4,  8'd4, 8'd0, 8'd9,  8'd0, 8'd9, 8'd4,  2'd2},  // R4 same-edge collision
        '{8'd0,  8'd3, 8'd0, 8'd5,  8'd0, 8'd0, 8'd1,  2'd1},  // R9 zero tier1 count
        '{8'd6,  8'd0, 8'd0, 8'd0,  8'd3, 8'd1, 8'd4,  2'd2},  // R9 zero tier2 count
        '{8'd15, 8'd7, 8'd0, 8'd20, 8'd0, 8'd6, 8'd15, 2'd1},  // R2 top count, tier2 just short
        '{8'd2,  8'd3, 8'd4, 8'd2,  8'd0, 8'd2, 8'd6,  2'd1},  // R2 delayed start
        '{8'd6,  8'd3, 8'd0, 8'd5,  8'd1, 8'd2, 8'd0,  2'd0}   // R3 both short
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Drive for one sample, return at the following falling edge.
    task automatic step(input logic f1, input logic f2);
        tier1_flag = f1;
        tier2_flag = f2;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        report();
        $finish;
    end

    initial begin
        int e1, win, f, r, ok;
        @(negedge clk);

        // R1 reset state
        tier1_blank = 4'd3; tier2_blank = 4'd2;
        do_reset();
        chk("R1 dsg_en", int'(dsg_en), 1);
        chk("R1 last_trip_t1", int'(last_trip_t1), 0);
        chk("R1 last_trip_t2", int'(last_trip_t2), 0);

        for (int i = 0; i < NV; i++) begin
            tier1_blank = VECS[i].b1[CNT_W-1:0];
            tier2_blank = VECS[i].b2[CNT_W-1:0];
            do_reset();
            e1  = (VECS[i].b1 == 0) ? 1 : int'(VECS[i].b1);
            win = (VECS[i].fall != 0) ? int'(VECS[i].fall) + MULT * e1 + 3 : 40;
            f = 0; r = 0;
            for (int n = 1; n <= win; n++) begin
                step((n > VECS[i].s1) && (n <= VECS[i].s1 + VECS[i].d1),
                     (n > VECS[i].s2) && (n <= VECS[i].s2 + VECS[i].d2));
                if (!dsg_en && f == 0) f = n;
                if (dsg_en && f != 0 && r == 0) r = n;
            end
            chk((VECS[i].cause == 2) ? "R4 trip sample" : "R2 trip sample", f, int'(VECS[i].fall));
            if (VECS[i].fall != 0)
                chk("R5 restore sample", r, int'(VECS[i].fall) + MULT * e1);
            chk("R8 last_trip_t1", int'(last_trip_t1), int'(VECS[i].cause == 1));
            chk("R8 last_trip_t2", int'(last_trip_t2), int'(VECS[i].cause == 2));
        end

        // R3: count restarts after a gap
        tier1_blank = 4'd4; tier2_blank = 4'd9;
        do_reset();
        for (int n = 0; n < 3; n++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        for (int n = 0; n < 3; n++) step(1'b1, 1'b0);
        chk("R3 no trip after split bursts", int'(dsg_en), 1);
        step(1'b1, 1'b0);
        chk("R3 trip on fourth of new burst", int'(dsg_en), 0);

        // R6, R7: sustained fault, retrip, flags ignored while off, recovery
        tier1_blank = 4'd2; tier2_blank = 4'd3;
        do_reset();
        for (int n = 1; n <= 38; n++) begin
            step(1'b1, 1'b0);
            if (n == 2)  chk("R2 sustained first trip", int'(dsg_en), 0);
            if (n == 35) chk("R5 still off", int'(dsg_en), 0);
            if (n == 36) chk("R6 restored", int'(dsg_en), 1);
            if (n == 37) chk("R6 fresh blanking", int'(dsg_en), 1);
            if (n == 38) chk("R6 retrip after B1", int'(dsg_en), 0);
        end
        for (int n = 39; n <= 70; n++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R6 tier2 ignored while off", int'(dsg_en), 0);
        step(1'b0, 1'b0);
        chk("R6 second restore", int'(dsg_en), 1);
        chk("R6 cause not changed by ignored flag", int'(last_trip_t2), 0);
        ok = 1;
        for (int n = 0; n < 50; n++) begin
            step(1'b0, 1'b0);
            if (!dsg_en) ok = 0;
        end
        chk("R7 stays enabled", ok, 1);
        chk("R8 status held", int'(last_trip_t1), 1);

        // R8: reset clears status
        rst = 1'b1;
        step(1'b0, 1'b0);
        rst = 1'b0;
        chk("R8 reset clears t1", int'(last_trip_t1), 0);

        // R5: off interval latched at trip
        tier1_blank = 4'd2;
        do_reset();
        f = 0; r = 0;
        for (int n = 1; n <= 45; n++) begin
            step(n <= 2, 1'b0);
            if (n == 2) tier1_blank = 4'd7;
            if (!dsg_en && f == 0) f = n;
            if (dsg_en && f != 0 && r == 0) r = n;
        end
        chk("R5 latched off length", r - f, 34);

        report();
        $finish;
    end
endmodule